// File: doc/BRIEF.md
# Prescaled Reloading Down-Counter Timer

A single-channel periodic timer that counts down in continuous mode. Ticks come from a two-stage divider chain. The first stage is a programmable 10-bit pre-divider that divides the clock by its stored value plus one. The second stage is a fixed prescaler that divides those ticks by 1, 16 or 256. On each tick the counter steps down by one. A tick that finds the counter at zero reloads it from the stored load value and raises a sticky pending flag. Software clears that flag with a strobe.

The load value can be written in two ways. The immediate path also overwrites the running count. The deferred path changes only the stored value, so it takes effect at the next zero. A width-mode input lets the counter act as a 16-bit counter. A debug-halt input, qualified by an enable pin, freezes the whole tick chain.

All control pins are plain levels and all writes are single-cycle strobes that are always accepted. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `prescaled_timer`

## Requirements
- R1: A cycle with `load_wr` high stores `wr_data` as the load value and as the count, visible on `count_o` one cycle later. If a tick falls in the same cycle, the load takes priority and no decrement or zero event happens.
- R2: A cycle with `reload_wr` high (and `load_wr` low) stores `wr_data` as the load value and leaves `count_o` unchanged. The count picks up the new value at the next zero event. A zero event in the same cycle as the write still reloads from the previous value.
- R3: The pre-divider register is 10 bits wide and resets to 0x07D. It is written through `div_wr`/`div_data`. It produces one pre-tick every (value+1) clocks, so the reset setting gives one pre-tick every 126 clocks.
- R4: `presc_sel` picks how many pre-ticks make one counter tick: 2'b00 gives 1, 2'b01 gives 16, 2'b10 gives 256 and 2'b11 gives 1.
- R5: The count changes only on ticks, and ticks occur only while `run_en` is 1. A tick on a nonzero count decrements it by one. A tick on a zero count is a zero event: it reloads the count from the load value and sets `pend_o`.
- R6: While `wide_mode` is 0, only the low 16 bits are decremented and tested for zero, and bits 31:16 of `count_o` read as 0. While it is 1, all 32 bits take part.
- R7: While `halt_en` and `dbg_halt` are both 1, the divider chain and the count are frozen. Once either input drops, counting resumes from the frozen state.
- R8: After reset, `count_o` is 0, `pend_o` is 0 and the load value is 0.
- R9: `pend_clr` clears `pend_o` one cycle later. If a zero event happens in the same cycle, `pend_o` is 1 instead.
- R10: While `run_en` is 0, both divider stages are held at their start state. With pre-divider value D and prescale P, the n-th tick after enabling lands n·(D+1)·P clocks after the cycle in which `run_en` is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enable |
| wide_mode | input | 1 | 1: 32-bit counter, 0: 16-bit counter |
| presc_sel | input | 2 | Prescale select (00 /1, 01 /16, 10 /256, 11 /1) |
| halt_en | input | 1 | Allows debug halt to freeze the timer |
| dbg_halt | input | 1 | Debug-halt request |
| div_wr | input | 1 | Pre-divider write strobe |
| div_data | input | 10 | Pre-divider write value |
| load_wr | input | 1 | Immediate load strobe |
| reload_wr | input | 1 | Deferred load strobe |
| wr_data | input | 32 | Load value for either strobe |
| pend_clr | input | 1 | Pending-flag clear strobe |
| count_o | output | 32 | Current count (upper half zero in 16-bit mode) |
| pend_o | output | 1 | Interrupt-pending flag |

## Verification
Results have two kinds of latency. Write strobes, including the pending clear, show on `count_o` or `pend_o` one cycle after the cycle in which they are sampled. Tick-driven changes land exactly n·(D+1)·P cycles after the cycle in which `run_en` is first seen. The driver records each expected value together with the absolute cycle index at which it is due. The monitor compares outputs at the falling edge of that cycle and nowhere else, and it reports an item as late if its cycle has already passed. Windows just before a tick are checked as well, so an early tick is caught in the same way as a late one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV16  = 2'b01,
    PS_DIV256 = 2'b10,
    PS_DIV1B  = 2'b11
  } presc_e;

  localparam int PS_W = 8;

  // terminal count of the second divider stage for each selection
  function automatic logic [PS_W-1:0] presc_limit(presc_e s);
    case (s)
      PS_DIV16:  return PS_W'(15);
      PS_DIV256: return PS_W'(255);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prediv.sv
module tmr_prediv #(
  parameter int               DIV_W   = 10,
  parameter logic [DIV_W-1:0] DIV_RST = 10'h07D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  output logic             pre_tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap     = (cnt_q >= div_q);
  assign pre_tick = run && !hold && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_RST;
      cnt_q <= '0;
    end else begin
      if (div_wr) div_q <= div_data;
      if (!run)       cnt_q <= '0;
      else if (!hold) cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  presc_e sel,
  input  logic   pre_tick,
  output logic   tick
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] lim;
  logic            wrap;

  assign lim  = presc_limit(sel);
  assign wrap = (cnt_q >= lim);
  assign tick = pre_tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (pre_tick) cnt_q <= wrap ? '0 : cnt_q + PS_W'(1);
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wide,
  input  logic             load_wr,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             pend
);
  localparam logic [CNT_W-1:0] NMASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_q;
  logic [CNT_W-1:0] cur;
  logic             zero_ev;

  assign cur     = wide ? cnt_q : (cnt_q & NMASK);
  assign zero_ev = tick && !load_wr && (cur == '0);
  assign count   = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ld_q  <= '0;
      pend  <= 1'b0;
    end else begin
      if (load_wr || reload_wr) ld_q <= wr_data;
      if (load_wr)      cnt_q <= wr_data;
      else if (zero_ev) cnt_q <= ld_q;
      else if (tick)    cnt_q <= cur - CNT_W'(1);
      if (zero_ev)  pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int               CNT_W    = 32,
  parameter int               NARROW_W = 16,
  parameter int               DIV_W    = 10,
  parameter logic [DIV_W-1:0] DIV_RST  = 10'h07D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             wide_mode,
  input  logic [1:0]       presc_sel,
  input  logic             halt_en,
  input  logic             dbg_halt,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  input  logic             load_wr,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pend_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             pend_o
);
  logic hold;
  logic pre_tick;
  logic tick;

  assign hold = halt_en && dbg_halt;

  tmr_prediv #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_prediv (
    .clk(clk), .rst_n(rst_n), .run(run_en), .hold(hold),
    .div_wr(div_wr), .div_data(div_data), .pre_tick(pre_tick)
  );

  tmr_prescale u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_en), .sel(presc_e'(presc_sel)),
    .pre_tick(pre_tick), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wide(wide_mode),
    .load_wr(load_wr), .reload_wr(reload_wr), .wr_data(wr_data),
    .clr(pend_clr), .count(count_o), .pend(pend_o)
  );
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             wide_mode,
  input logic             halt_en,
  input logic             dbg_halt,
  input logic             load_wr,
  input logic             reload_wr,
  input logic [CNT_W-1:0] wr_data,
  input logic             pend_clr,
  input logic [CNT_W-1:0] count_o,
  input logic             pend_o,
  input logic             tick
);
  p_load_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (!wide_mode || !$past(wide_mode) || count_o == $past(wr_data)));

  p_reload_defer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && !load_wr && !tick) |=> (!$stable(wide_mode) || $stable(count_o)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_wr) |=> (!$stable(wide_mode) || $stable(count_o)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && count_o != '0) |=>
      (!$stable(wide_mode) || count_o == $past(count_o) - CNT_W'(1)));

  p_zero_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && count_o == '0) |=> pend_o);

  p_halt_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en && dbg_halt) |-> !tick);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !(tick && !load_wr && count_o == '0)) |=> !pend_o);
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .wide_mode(wide_mode),
  .halt_en(halt_en), .dbg_halt(dbg_halt), .load_wr(load_wr),
  .reload_wr(reload_wr), .wr_data(wr_data), .pend_clr(pend_clr),
  .count_o(count_o), .pend_o(pend_o), .tick(tick)
);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, wide_mode = 1'b1, halt_en = 1'b0, dbg_halt = 1'b0;
  logic [1:0]  presc_sel = 2'b00;
  logic        div_wr = 1'b0, load_wr = 1'b0, reload_wr = 1'b0, pend_clr = 1'b0;
  logic [9:0]  div_data = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o;
  logic        pend_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [31:0] val;
    logic        pend;
    string       tag;
  } exp_t;
  exp_t sb[$];

  prescaled_timer u_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wide_mode(wide_mode),
    .presc_sel(presc_sel), .halt_en(halt_en), .dbg_halt(dbg_halt),
    .div_wr(div_wr), .div_data(div_data), .load_wr(load_wr),
    .reload_wr(reload_wr), .wr_data(wr_data), .pend_clr(pend_clr),
    .count_o(count_o), .pend_o(pend_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs at the falling edge of each due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      n_chk++;
      if (it.due != cyc) begin
        n_bad++;
        $display("FAIL %s: item due at cycle %0d compared late at %0d", it.tag, it.due, cyc);
      end else if (count_o !== it.val || pend_o !== it.pend) begin
        n_bad++;
        $display("FAIL %s: cycle %0d count=%h pend=%b expected count=%h pend=%b",
                 it.tag, cyc, count_o, pend_o, it.val, it.pend);
      end
    end
  end

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int dt, logic [31:0] v, logic p, string tag);
    exp_t it;
    it.due = cyc + dt; it.val = v; it.pend = p; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_load(logic [31:0] d);
    load_wr = 1'b1; wr_data = d; tk(1); load_wr = 1'b0;
  endtask

  task automatic do_div(logic [9:0] d);
    div_wr = 1'b1; div_data = d; tk(1); div_wr = 1'b0;
  endtask

  task automatic do_clr(logic [31:0] v);
    expect_at(1, v, 1'b0, "R9");
    pend_clr = 1'b1; tk(1); pend_clr = 1'b0;
  endtask

  initial begin
    tk(3);
    rst_n = 1'b1;
    expect_at(1, 32'd0, 1'b0, "R8");
    tk(2);

    // immediate load while stopped, then hold
    expect_at(1, 32'd5, 1'b0, "R1");
    do_load(32'd5);
    expect_at(9, 32'd5, 1'b0, "R5");
    tk(10);

    // default pre-divider: 126 clocks per tick
    run_en = 1'b1;
    expect_at(125, 32'd5, 1'b0, "R3");
    expect_at(126, 32'd4, 1'b0, "R3");
    expect_at(252, 32'd3, 1'b0, "R3");
    tk(253); run_en = 1'b0;

    // pre-divider 1, prescale /16: 32 clocks
    do_div(10'd1);
    presc_sel = 2'b01; run_en = 1'b1;
    expect_at(31, 32'd3, 1'b0, "R4");
    expect_at(32, 32'd2, 1'b0, "R4");
    tk(33); run_en = 1'b0;

    // pre-divider 0, prescale /256
    do_div(10'd0);
    presc_sel = 2'b10; run_en = 1'b1;
    expect_at(255, 32'd2, 1'b0, "R4");
    expect_at(256, 32'd1, 1'b0, "R4");
    tk(257); run_en = 1'b0;

    // code 11 is /1, and zero event reloads 5
    presc_sel = 2'b11; run_en = 1'b1;
    expect_at(1, 32'd0, 1'b0, "R4");
    expect_at(2, 32'd5, 1'b1, "R5");
    expect_at(3, 32'd4, 1'b1, "R5");
    tk(3); run_en = 1'b0;
    do_clr(32'd4);

    // deferred load
    expect_at(1, 32'd4, 1'b0, "R2");
    reload_wr = 1'b1; wr_data = 32'd7; tk(1); reload_wr = 1'b0;
    presc_sel = 2'b00; run_en = 1'b1;
    expect_at(1, 32'd3, 1'b0, "R2");
    expect_at(2, 32'd2, 1'b0, "R2");
    expect_at(3, 32'd1, 1'b0, "R2");
    expect_at(4, 32'd0, 1'b0, "R2");
    expect_at(5, 32'd7, 1'b1, "R2");
    tk(5); run_en = 1'b0;
    do_clr(32'd7);

    // clear coinciding with a zero event
    expect_at(1, 32'd0, 1'b0, "R1");
    do_load(32'd0);
    run_en = 1'b1;
    expect_at(1, 32'd0, 1'b1, "R5");
    tk(2);
    pend_clr = 1'b1;
    expect_at(1, 32'd0, 1'b1, "R9");
    tk(1); pend_clr = 1'b0; run_en = 1'b0;
    do_clr(32'd0);
    tk(1);

    // 16-bit mode
    wide_mode = 1'b0;
    expect_at(1, 32'd2, 1'b0, "R6");
    do_load(32'h0001_0002);
    run_en = 1'b1;
    expect_at(1, 32'd1, 1'b0, "R6");
    expect_at(2, 32'd0, 1'b0, "R6");
    expect_at(3, 32'd2, 1'b1, "R6");
    tk(3); run_en = 1'b0;
    do_clr(32'd2);
    tk(1);
    wide_mode = 1'b1;
    tk(1);
    expect_at(1, 32'h0001_0000, 1'b0, "R6");
    do_load(32'h0001_0000);
    run_en = 1'b1;
    expect_at(1, 32'h0000_FFFF, 1'b0, "R6");
    tk(1); run_en = 1'b0;
    tk(1);
    wide_mode = 1'b0;
    tk(1);
    expect_at(1, 32'd0, 1'b0, "R6");
    do_load(32'h0001_0000);
    run_en = 1'b1;
    expect_at(1, 32'd0, 1'b1, "R6");
    tk(1); run_en = 1'b0;
    do_clr(32'd0);
    tk(1);
    wide_mode = 1'b1;
    tk(1);

    // debug halt freeze
    expect_at(1, 32'd20, 1'b0, "R1");
    do_load(32'd20);
    halt_en = 1'b1; dbg_halt = 1'b1; run_en = 1'b1;
    expect_at(1, 32'd20, 1'b0, "R7");
    expect_at(5, 32'd20, 1'b0, "R7");
    tk(5);
    halt_en = 1'b0;
    expect_at(1, 32'd19, 1'b0, "R7");
    expect_at(2, 32'd18, 1'b0, "R7");
    tk(2);
    halt_en = 1'b1; dbg_halt = 1'b0;
    expect_at(1, 32'd17, 1'b0, "R7");
    tk(1); run_en = 1'b0; halt_en = 1'b0;

    // divider chain restarts after a disable
    do_div(10'd1);
    expect_at(1, 32'd10, 1'b0, "R1");
    do_load(32'd10);
    run_en = 1'b1;
    expect_at(1, 32'd10, 1'b0, "R10");
    expect_at(2, 32'd9, 1'b0, "R10");
    tk(3); run_en = 1'b0;
    tk(2); run_en = 1'b1;
    expect_at(1, 32'd9, 1'b0, "R10");
    expect_at(2, 32'd8, 1'b0, "R10");
    tk(2); run_en = 1'b0;

    // load wins over a same-cycle tick
    do_div(10'd0);
    run_en = 1'b1;
    tk(1);
    expect_at(1, 32'd9, 1'b0, "R1");
    load_wr = 1'b1; wr_data = 32'd9; tk(1); load_wr = 1'b0;
    expect_at(1, 32'd8, 1'b0, "R1");
    tk(1); run_en = 1'b0;
    tk(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion within 5000 cycles");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule